// File: doc/BRIEF.md
# Age-Ordered Multi-Class Issue Selector

This block sits between the wakeup logic and the execution units of an out-of-order core. Instructions that are ready to execute are written into one small ready pool per operation class, each tagged with a sequence number and an opaque payload. Keeping one pool per class lets each class feed its own functional unit directly.

Every cycle the block compares the oldest entry of each class against the oldest entries of all the others. It then presents up to a fixed number of issue slots, with slot 0 holding the globally oldest candidate. A class whose functional unit reports busy is passed over, and the next-oldest class moves up into its slot. Sequence numbers are compared modulo their width, so the tag counter may wrap freely as long as live entries span less than half its range.

A squash request flushes every pooled entry younger than a given sequence number in a single cycle. The block exposes one full flag per class so that the producer can hold back writes to a class that has no free slot.

Top module: `age_issue_select`

## Requirements
- R1: After reset all pools are empty: no issue slot is valid and no class reports full.
- R2: An entry written through the enqueue port can be issued from the following cycle onward, never in the cycle of its write.
- R3: Within one class, the entry with the oldest sequence number is always the one offered for issue, regardless of the order in which the entries were written.
- R4: Issue slots are filled without gaps from slot 0 upward, and each slot holds an entry that is older than the entry in the next slot. Slot 0 holds the oldest head among the eligible classes.
- R5: At most ISSUE_W entries issue per cycle, and at most one of them comes from any one class.
- R6: A class whose fuBusy bit is set issues nothing that cycle, and the remaining classes fill the slots in age order.
- R7: Sequence number a counts as older than b when the most significant bit of (a - b), taken modulo 2^SEQ_W, is 1. For example, 8'hF0 is older than 8'h05.
- R8: When squashValid is high, every entry that is younger than squashSeq is removed at the clock edge, and entries that are equal to it or older than it stay. In that cycle no slot issues and the enqueue input is ignored.
- R9: classFull[c] is high while class c holds POOL_DEPTH entries. A write to a full class is dropped.
- R10: An entry presented in a valid issue slot is removed from its pool at the clock edge ending that cycle and is not offered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| enqValid | input | 1 | Write one ready entry this cycle |
| enqClass | input | $clog2(NUM_CLASSES) | Operation class of the written entry |
| enqSeq | input | SEQ_W | Sequence number of the written entry |
| enqPayload | input | PAY_W | Payload carried with the entry |
| classFull | output | NUM_CLASSES | Per-class pool full flag |
| fuBusy | input | NUM_CLASSES | Per-class functional unit busy, blocks issue from that class |
| squashValid | input | 1 | Flush entries younger than squashSeq |
| squashSeq | input | SEQ_W | Squash point |
| issueValid | output | ISSUE_W | Slot k carries an issued entry |
| issueClass | output | ISSUE_W x $clog2(NUM_CLASSES) | Class of the entry in each slot |
| issueSeq | output | ISSUE_W x SEQ_W | Sequence number in each slot |
| issuePayload | output | ISSUE_W x PAY_W | Payload in each slot |

## Verification
The issue slots and the full flags are combinational functions of the registered pools and of this cycle's fuBusy and squashValid. They are therefore due in the same cycle as those inputs, while a write, an issue removal or a squash shows up only in the following cycle. The bench drives every input at the falling edge and samples all outputs one time unit later, so each comparison sees the pool state left by the previous rising edge together with the current inputs. A reference model kept in the bench is updated once per cycle after that comparison, which mirrors the one-edge delay between a stimulus and its effect on the pools.

// File: rtl/issue_sel_pkg.sv
package issue_sel_pkg;

  // Strobes the control half hands to the pool datapath each cycle.
  typedef struct packed {
    logic doPush;    // accept the enqueue port this cycle
    logic doIssue;   // remove entries picked for issue
    logic doSquash;  // flush younger entries
  } selStrobe_t;

endpackage

// File: rtl/ready_pools.sv
module ready_pools
  import issue_sel_pkg::*;
#(
  parameter int NUM_CLASSES = 4,
  parameter int POOL_DEPTH  = 8,
  parameter int SEQ_W       = 8,
  parameter int PAY_W       = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  selStrobe_t                         strobe,
  input  logic [NUM_CLASSES-1:0]             popMask,
  input  logic [$clog2(NUM_CLASSES)-1:0]     enqClass,
  input  logic [SEQ_W-1:0]                   enqSeq,
  input  logic [PAY_W-1:0]                   enqPayload,
  input  logic [SEQ_W-1:0]                   squashSeq,
  output logic [NUM_CLASSES-1:0]             headValid,
  output logic [NUM_CLASSES-1:0][SEQ_W-1:0]  headSeq,
  output logic [NUM_CLASSES-1:0][PAY_W-1:0]  headPay,
  output logic [NUM_CLASSES-1:0]             poolFull
);

  localparam int CW = $clog2(NUM_CLASSES);
  localparam int DW = $clog2(POOL_DEPTH);

  // Wrap-aware age test: a is older than b when (a - b) is negative.
  function automatic logic older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] diff;
    diff = a - b;
    return diff[SEQ_W-1];
  endfunction

  for (genvar c = 0; c < NUM_CLASSES; c++) begin : gPool
    logic [POOL_DEPTH-1:0] vld;
    logic [SEQ_W-1:0]      seqMem [POOL_DEPTH];
    logic [PAY_W-1:0]      payMem [POOL_DEPTH];
    logic [DW-1:0]         hIdx;
    logic                  hFound;
    logic [DW-1:0]         fIdx;
    logic                  isFull;
    logic                  pushHere;

    // Oldest valid entry of this class.
    always_comb begin
      hIdx   = '0;
      hFound = 1'b0;
      for (int d = 0; d < POOL_DEPTH; d++) begin
        if (vld[d] && (!hFound || older(seqMem[d], seqMem[hIdx]))) begin
          hIdx   = DW'(d);
          hFound = 1'b1;
        end
      end
    end

    // Lowest free slot.
    always_comb begin
      fIdx = '0;
      for (int d = POOL_DEPTH - 1; d >= 0; d--) begin
        if (!vld[d]) fIdx = DW'(d);
      end
    end

    assign isFull   = &vld;
    assign pushHere = strobe.doPush && (enqClass == CW'(c)) && !isFull;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vld <= '0;
      end else if (strobe.doSquash) begin
        for (int d = 0; d < POOL_DEPTH; d++) begin
          if (vld[d] && older(squashSeq, seqMem[d])) vld[d] <= 1'b0;
        end
      end else begin
        if (strobe.doIssue && popMask[c]) vld[hIdx] <= 1'b0;
        if (pushHere) vld[fIdx] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (pushHere) begin
        seqMem[fIdx] <= enqSeq;
        payMem[fIdx] <= enqPayload;
      end
    end

    assign headValid[c] = hFound;
    assign headSeq[c]   = seqMem[hIdx];
    assign headPay[c]   = payMem[hIdx];
    assign poolFull[c]  = isFull;
  end

endmodule

// File: rtl/age_select_ctrl.sv
module age_select_ctrl
  import issue_sel_pkg::*;
#(
  parameter int NUM_CLASSES = 4,
  parameter int ISSUE_W     = 2,
  parameter int SEQ_W       = 8
) (
  input  logic                                         enqValid,
  input  logic                                         squashValid,
  input  logic [NUM_CLASSES-1:0]                       fuBusy,
  input  logic [NUM_CLASSES-1:0]                       headValid,
  input  logic [NUM_CLASSES-1:0][SEQ_W-1:0]            headSeq,
  output selStrobe_t                                   strobe,
  output logic [NUM_CLASSES-1:0]                       popMask,
  output logic [ISSUE_W-1:0]                           slotValid,
  output logic [ISSUE_W-1:0][$clog2(NUM_CLASSES)-1:0]  slotClass
);

  localparam int CW = $clog2(NUM_CLASSES);
  localparam int RW = $clog2(NUM_CLASSES + 1);

  function automatic logic older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] diff;
    diff = a - b;
    return diff[SEQ_W-1];
  endfunction

  logic [NUM_CLASSES-1:0]         eligible;
  logic [NUM_CLASSES-1:0][RW-1:0] rank;

  assign eligible = headValid & ~fuBusy & {NUM_CLASSES{~squashValid}};

  // Age order of the class heads: rank = number of eligible heads ahead of it.
  always_comb begin
    for (int c = 0; c < NUM_CLASSES; c++) begin
      rank[c] = '0;
      for (int j = 0; j < NUM_CLASSES; j++) begin
        if (j != c && eligible[j] &&
            (older(headSeq[j], headSeq[c]) || (headSeq[j] == headSeq[c] && j < c)))
          rank[c] = rank[c] + RW'(1);
      end
      popMask[c] = eligible[c] && (rank[c] < RW'(ISSUE_W));
    end
  end

  for (genvar k = 0; k < ISSUE_W; k++) begin : gSlot
    always_comb begin
      slotValid[k] = 1'b0;
      slotClass[k] = '0;
      for (int c = 0; c < NUM_CLASSES; c++) begin
        if (popMask[c] && rank[c] == RW'(k)) begin
          slotValid[k] = 1'b1;
          slotClass[k] = CW'(c);
        end
      end
    end
  end

  assign strobe.doPush   = enqValid && !squashValid;
  assign strobe.doIssue  = !squashValid;
  assign strobe.doSquash = squashValid;

endmodule

// File: rtl/age_issue_select.sv
module age_issue_select
  import issue_sel_pkg::*;
#(
  parameter int NUM_CLASSES = 4,
  parameter int POOL_DEPTH  = 8,
  parameter int ISSUE_W     = 2,
  parameter int SEQ_W       = 8,
  parameter int PAY_W       = 8
) (
  input  logic                                         clk,
  input  logic                                         rstN,
  input  logic                                         enqValid,
  input  logic [$clog2(NUM_CLASSES)-1:0]               enqClass,
  input  logic [SEQ_W-1:0]                             enqSeq,
  input  logic [PAY_W-1:0]                             enqPayload,
  output logic [NUM_CLASSES-1:0]                       classFull,
  input  logic [NUM_CLASSES-1:0]                       fuBusy,
  input  logic                                         squashValid,
  input  logic [SEQ_W-1:0]                             squashSeq,
  output logic [ISSUE_W-1:0]                           issueValid,
  output logic [ISSUE_W-1:0][$clog2(NUM_CLASSES)-1:0]  issueClass,
  output logic [ISSUE_W-1:0][SEQ_W-1:0]                issueSeq,
  output logic [ISSUE_W-1:0][PAY_W-1:0]                issuePayload
);

  selStrobe_t                        strobe;
  logic [NUM_CLASSES-1:0]            popMask;
  logic [NUM_CLASSES-1:0]            headValid;
  logic [NUM_CLASSES-1:0][SEQ_W-1:0] headSeq;
  logic [NUM_CLASSES-1:0][PAY_W-1:0] headPay;

  age_select_ctrl #(
    .NUM_CLASSES(NUM_CLASSES), .ISSUE_W(ISSUE_W), .SEQ_W(SEQ_W)
  ) ctrl_i (
    .enqValid(enqValid), .squashValid(squashValid), .fuBusy(fuBusy),
    .headValid(headValid), .headSeq(headSeq), .strobe(strobe),
    .popMask(popMask), .slotValid(issueValid), .slotClass(issueClass)
  );

  ready_pools #(
    .NUM_CLASSES(NUM_CLASSES), .POOL_DEPTH(POOL_DEPTH), .SEQ_W(SEQ_W), .PAY_W(PAY_W)
  ) pools_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .popMask(popMask),
    .enqClass(enqClass), .enqSeq(enqSeq), .enqPayload(enqPayload),
    .squashSeq(squashSeq), .headValid(headValid), .headSeq(headSeq),
    .headPay(headPay), .poolFull(classFull)
  );

  always_comb begin
    for (int k = 0; k < ISSUE_W; k++) begin
      issueSeq[k]     = issueValid[k] ? headSeq[issueClass[k]] : '0;
      issuePayload[k] = issueValid[k] ? headPay[issueClass[k]] : '0;
    end
  end

endmodule

// File: rtl/age_issue_select_chk.sv
module age_issue_select_chk #(
  parameter int NUM_CLASSES = 4,
  parameter int ISSUE_W     = 2,
  parameter int SEQ_W       = 8
) (
  input logic                                         clk,
  input logic                                         rstN,
  input logic [NUM_CLASSES-1:0]                       fuBusy,
  input logic                                         squashValid,
  input logic [ISSUE_W-1:0]                           issueValid,
  input logic [ISSUE_W-1:0][$clog2(NUM_CLASSES)-1:0]  issueClass,
  input logic [ISSUE_W-1:0][SEQ_W-1:0]                issueSeq
);

  function automatic logic older(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] diff;
    diff = a - b;
    return diff[SEQ_W-1];
  endfunction

  // R1: leaving reset, nothing is offered.
  a_r1_empty_after_reset: assert property (@(posedge clk)
    $rose(rstN) |-> issueValid == '0);

  // R8: squash cycle issues nothing.
  a_r8_quiet_on_squash: assert property (@(posedge clk) disable iff (!rstN)
    squashValid |-> issueValid == '0);

  for (genvar k = 0; k < ISSUE_W; k++) begin : gChk
    // R6: a busy class never fills a slot.
    a_r6_busy_skipped: assert property (@(posedge clk) disable iff (!rstN)
      issueValid[k] |-> !fuBusy[issueClass[k]]);

    if (k > 0) begin : gOrder
      // R4: slots packed from 0 and ordered oldest first.
      a_r4_slot_order: assert property (@(posedge clk) disable iff (!rstN)
        issueValid[k] |-> issueValid[k-1] && older(issueSeq[k-1], issueSeq[k]));

      for (genvar j = 0; j < k; j++) begin : gPair
        // R5: one entry per class per cycle.
        a_r5_one_per_class: assert property (@(posedge clk) disable iff (!rstN)
          (issueValid[k] && issueValid[j]) |-> issueClass[k] != issueClass[j]);
      end
    end
  end

endmodule

bind age_issue_select age_issue_select_chk #(
  .NUM_CLASSES(NUM_CLASSES), .ISSUE_W(ISSUE_W), .SEQ_W(SEQ_W)
) chk_i (
  .clk(clk), .rstN(rstN), .fuBusy(fuBusy), .squashValid(squashValid),
  .issueValid(issueValid), .issueClass(issueClass), .issueSeq(issueSeq)
);

// File: tb/age_issue_select_tb_top.sv
module age_issue_select_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 4;
  localparam int DEPTH = 8;
  localparam int IW = 2;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enqValid = 1'b0;
  logic [1:0] enqClass = '0;
  logic [7:0] enqSeq = '0;
  logic [7:0] enqPayload = '0;
  logic [NC-1:0] classFull;
  logic [NC-1:0] fuBusy = '0;
  logic squashValid = 1'b0;
  logic [7:0] squashSeq = '0;
  logic [IW-1:0] issueValid;
  logic [IW-1:0][1:0] issueClass;
  logic [IW-1:0][7:0] issueSeq;
  logic [IW-1:0][7:0] issuePayload;

  always #(CLK_PERIOD/2) clk = ~clk;

  age_issue_select #(
    .NUM_CLASSES(NC), .POOL_DEPTH(DEPTH), .ISSUE_W(IW), .SEQ_W(8), .PAY_W(8)
  ) dut_i (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqClass(enqClass),
    .enqSeq(enqSeq), .enqPayload(enqPayload), .classFull(classFull),
    .fuBusy(fuBusy), .squashValid(squashValid), .squashSeq(squashSeq),
    .issueValid(issueValid), .issueClass(issueClass), .issueSeq(issueSeq),
    .issuePayload(issuePayload)
  );

  int nChecks = 0;
  int nErrors = 0;
  int cycles = 0;
  string curTag = "R4";

  // Reference model of the pools.
  bit       mV [NC][DEPTH];
  bit [7:0] mS [NC][DEPTH];
  bit [7:0] mP [NC][DEPTH];
  bit       expV [IW];
  int       expC [IW];

  function automatic bit olderRef(input bit [7:0] a, input bit [7:0] b);
    bit [7:0] d;
    d = a - b;
    return d[7];
  endfunction

  function automatic int poolCount(input int c);
    int n = 0;
    for (int d = 0; d < DEPTH; d++) if (mV[c][d]) n++;
    return n;
  endfunction

  function automatic int headSlot(input int c);
    int h = -1;
    for (int d = 0; d < DEPTH; d++)
      if (mV[c][d] && (h < 0 || olderRef(mS[c][d], mS[c][h]))) h = d;
    return h;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nErrors++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic computeExpected(input bit [NC-1:0] busy, input bit sq);
    bit taken [NC];
    for (int c = 0; c < NC; c++) taken[c] = 1'b0;
    for (int k = 0; k < IW; k++) begin
      int best = -1;
      for (int c = 0; c < NC; c++) begin
        int h = headSlot(c);
        if (h >= 0 && !busy[c] && !sq && !taken[c]) begin
          if (best < 0 || olderRef(mS[c][h], mS[best][headSlot(best)])) best = c;
        end
      end
      expV[k] = (best >= 0);
      expC[k] = best;
      if (best >= 0) taken[best] = 1'b1;
    end
  endtask

  // One cycle: drive at the falling edge, compare, then advance the model.
  task automatic step(input bit ev, input int ec, input bit [7:0] es,
                      input bit [NC-1:0] busy, input bit sq, input bit [7:0] sqs);
    bit [NC-1:0] expFull;
    bit wasFull;
    @(negedge clk);
    enqValid = ev; enqClass = ec[1:0]; enqSeq = es; enqPayload = es ^ 8'h5A;
    fuBusy = busy; squashValid = sq; squashSeq = sqs;
    #1;
    computeExpected(busy, sq);
    for (int c = 0; c < NC; c++) expFull[c] = (poolCount(c) == DEPTH);
    chk(classFull == expFull, curTag, "classFull", classFull, expFull);
    for (int k = 0; k < IW; k++) begin
      chk(issueValid[k] == expV[k], curTag, $sformatf("issueValid[%0d]", k),
          issueValid[k], expV[k]);
      if (expV[k]) begin
        int h = headSlot(expC[k]);
        chk(issueClass[k] == expC[k][1:0], curTag, $sformatf("issueClass[%0d]", k),
            issueClass[k], expC[k]);
        chk(issueSeq[k] == mS[expC[k]][h], curTag, $sformatf("issueSeq[%0d]", k),
            issueSeq[k], mS[expC[k]][h]);
        chk(issuePayload[k] == mP[expC[k]][h], curTag, $sformatf("issuePayload[%0d]", k),
            issuePayload[k], mP[expC[k]][h]);
      end
    end
    // Model update (effect of the coming rising edge).
    if (sq) begin
      for (int c = 0; c < NC; c++)
        for (int d = 0; d < DEPTH; d++)
          if (mV[c][d] && olderRef(sqs, mS[c][d])) mV[c][d] = 1'b0;
    end else begin
      wasFull = (poolCount(ec) == DEPTH);
      for (int k = 0; k < IW; k++)
        if (expV[k]) mV[expC[k]][headSlot(expC[k])] = 1'b0;
      if (ev && !wasFull) begin
        for (int d = 0; d < DEPTH; d++) begin
          if (!mV[ec][d]) begin
            mV[ec][d] = 1'b1; mS[ec][d] = es; mP[ec][d] = es ^ 8'h5A;
            break;
          end
        end
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 0, 8'h00, '0, 1'b0, 8'h00);
  endtask

  function automatic int modelTotal();
    int n = 0;
    for (int c = 0; c < NC; c++) n += poolCount(c);
    return n;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles >= WATCHDOG) begin
      nErrors++;
      $display("FAIL watchdog: got %0d cycles expected fewer than %0d", cycles, WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
      $finish;
    end
  end

  initial begin
    bit [7:0] nextSeq;
    for (int c = 0; c < NC; c++) for (int d = 0; d < DEPTH; d++) mV[c][d] = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    // R1: empty after reset
    chk(issueValid == '0, "R1", "issueValid after reset", issueValid, 0);
    chk(classFull == '0, "R1", "classFull after reset", classFull, 0);

    // R2: a write is not issued in its own cycle, only in the next one.
    curTag = "R2";
    step(1'b1, 1, 8'h10, '0, 1'b0, 8'h00);
    chk(issueValid == '0, "R2", "issue in write cycle", issueValid, 0);
    curTag = "R10";
    step(1'b0, 0, 8'h00, '0, 1'b0, 8'h00);
    // R10: issued entry is gone the next cycle
    step(1'b0, 0, 8'h00, '0, 1'b0, 8'h00);
    chk(issueValid == '0, "R10", "reissue after removal", issueValid, 0);

    // R3: out-of-order writes into one class, drained oldest first.
    curTag = "R3";
    step(1'b1, 0, 8'h32, 4'b0001, 1'b0, 8'h00);
    step(1'b1, 0, 8'h28, 4'b0001, 1'b0, 8'h00);
    step(1'b1, 0, 8'h2D, 4'b0001, 1'b0, 8'h00);
    step(1'b1, 0, 8'h1E, 4'b0001, 1'b0, 8'h00);
    step(1'b0, 0, 8'h00, 4'b0001, 1'b0, 8'h00);
    chk(issueValid == '0, "R3", "busy class held", issueValid, 0);
    idle(5);

    // R7: wrap-aware ordering across classes (F0 < FA < 05 < 10 in age).
    curTag = "R7";
    step(1'b1, 0, 8'hF0, 4'b1111, 1'b0, 8'h00);
    step(1'b1, 1, 8'h05, 4'b1111, 1'b0, 8'h00);
    step(1'b1, 2, 8'hFA, 4'b1111, 1'b0, 8'h00);
    step(1'b1, 3, 8'h10, 4'b1111, 1'b0, 8'h00);
    step(1'b0, 0, 8'h00, 4'b0000, 1'b0, 8'h00);
    chk(issueSeq[0] == 8'hF0 && issueSeq[1] == 8'hFA, "R7", "wrapped order",
        {issueSeq[0], issueSeq[1]}, 16'hF0FA);
    idle(3);

    // R6: busy oldest class is skipped.
    curTag = "R6";
    step(1'b1, 0, 8'h20, 4'b1111, 1'b0, 8'h00);
    step(1'b1, 1, 8'h21, 4'b1111, 1'b0, 8'h00);
    step(1'b1, 2, 8'h22, 4'b1111, 1'b0, 8'h00);
    step(1'b0, 0, 8'h00, 4'b0001, 1'b0, 8'h00);
    chk(issueClass[0] == 2'd1 && issueClass[1] == 2'd2, "R6", "classes after skip",
        {issueClass[0], issueClass[1]}, 4'b0110);
    idle(3);

    // R5: more eligible classes than slots, two entries in one class.
    curTag = "R5";
    step(1'b1, 3, 8'h30, 4'b1111, 1'b0, 8'h00);
    step(1'b1, 3, 8'h31, 4'b1111, 1'b0, 8'h00);
    step(1'b1, 0, 8'h32, 4'b1111, 1'b0, 8'h00);
    step(1'b1, 1, 8'h33, 4'b1111, 1'b0, 8'h00);
    step(1'b0, 0, 8'h00, 4'b0000, 1'b0, 8'h00);
    chk(issueClass[0] == 2'd3 && issueClass[1] == 2'd0, "R5", "one per class",
        {issueClass[0], issueClass[1]}, 4'b1100);
    idle(4);

    // R9: fill class 2, ninth write dropped.
    curTag = "R9";
    for (int i = 0; i < 9; i++) step(1'b1, 2, 8'h40 + 8'(i), 4'b0100, 1'b0, 8'h00);
    step(1'b0, 0, 8'h00, 4'b0100, 1'b0, 8'h00);
    chk(classFull[2] == 1'b1, "R9", "classFull[2]", classFull[2], 1);
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 0, 8'h00, 4'b0000, 1'b0, 8'h00);
      chk(issueValid[0] == 1'b1 && issueSeq[0] == 8'h40 + 8'(i), "R9", "drain order",
          issueSeq[0], 8'h40 + 8'(i));
    end
    step(1'b0, 0, 8'h00, 4'b0000, 1'b0, 8'h00);
    chk(issueValid == '0, "R9", "dropped write absent", issueValid, 0);

    // R8: squash across a wrap, with a write in the squash cycle.
    curTag = "R8";
    for (int i = 0; i < 8; i++) step(1'b1, i % NC, 8'hFA + 8'(i), 4'b1111, 1'b0, 8'h00);
    step(1'b1, 1, 8'hF0, 4'b1111, 1'b1, 8'hFD);
    chk(issueValid == '0, "R8", "issue during squash", issueValid, 0);
    step(1'b0, 0, 8'h00, 4'b1111, 1'b0, 8'h00);
    idle(5);
    chk(modelTotal() == 0, "R8", "model empty after drain", modelTotal(), 0);

    // Sweep: random classes, busy patterns and occasional squashes.
    curTag = "R4";
    nextSeq = 8'hC0;
    for (int blk = 0; blk < 60; blk++) begin
      for (int i = 0; i < 30; i++) begin
        int cls = int'($urandom % NC);
        bit [NC-1:0] busy = NC'($urandom) & NC'($urandom);
        bit ev = ($urandom % 4) != 0;
        bit sq = ($urandom % 25) == 0;
        bit [7:0] sqs = nextSeq - 8'($urandom % 10);
        step(ev, cls, nextSeq, busy, sq, sqs);
        if (ev && !sq) nextSeq = nextSeq + 8'd1;
      end
      idle(10);
    end

    $display("Simulation finished: %0d checks, %0d errors", nChecks, nErrors);
    $finish;
  end

endmodule